// File: doc/BRIEF.md
# Register File with Context Banks

This block is the general-purpose register array of a 32-bit processor core. It also holds four shadow banks that keep a thread's working context, so a thread switch needs no stack traffic. The live array has 32 words and is built from flip-flops rather than a RAM macro. That lets every context register be read and written in the same clock edge. Two combinational read ports and one clocked write port serve the datapath as usual.

A thread's context is twelve registers: 16 to 23, 28, 29, 30 and 31. A save copies those twelve live words into one shadow bank in a single cycle. A restore copies a shadow bank back into the same twelve live registers, also in one cycle. A save or restore can be requested in two ways. The first is explicit strobes that carry a bank index. The second is a valid 32-bit instruction word, which the block decodes itself when it carries the context-save or context-restore function code.

Top module: `ctxrf_top`

## Requirements
- R1: Reset (active-low `rst_n`) clears all 32 live registers and all four shadow banks to zero.
- R2: Register 0 always reads zero. A write to it is ignored, and save or restore never touches it.
- R3: A write with `wr_en` high updates the addressed register at the clock edge. Both read ports are combinational and return the stored value, with no bypass of a write in the same cycle.
- R4: A save copies live registers 16..23, 28, 29, 30 and 31 into the selected bank in one edge. A restore copies that bank back into the same registers in one edge, visible on the read ports in the next cycle.
- R5: The four banks are independent. Only the bank named by the 2-bit index changes on a save.
- R6: Registers outside the context set (1..15, 24..27) are never changed by a save or a restore.
- R7: A valid instruction (`instr_vld` high) with bits [31:26] = 000000 and bits [5:0] = 111100 is a save; with bits [5:0] = 111101 it is a restore. The bank index is bits [17:16], and bits [20:18] are ignored.
- R8: An instruction with another major opcode, another function code, or `instr_vld` low causes no save and no restore.
- R9: When a write and a restore occur in the same cycle, the restore wins for the twelve context registers. A write to any other register still completes.
- R10: A save in the same cycle as a write to a context register stores the value the register held before that edge.
- R11: A save and a restore of the same bank in one cycle swap the contents: the bank takes the old live values and the live registers take the old bank values.
- R12: When `save_stb` or `restore_stb` is high, the instruction input is ignored for that cycle, and the strobes with `stb_bank` set the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| save_stb | input | 1 | Explicit context save request |
| restore_stb | input | 1 | Explicit context restore request |
| stb_bank | input | 2 | Bank index for the strobes |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word, decoded for save and restore |

## Verification
The round trip of save, corruption and restore is run on each of the four banks with a different fill pattern per bank. This shows that the banks are independent and that the twelve-register slot map is correct, while untouched non-context registers show that the mapping does not spill over. Instruction words with junk in the upper bank bits, wrong opcodes, wrong function codes and a low valid separate a correct decode from one that is too loose. Same-cycle collisions (write with restore, write with save, save with restore, strobe with instruction) pin down the ordering rules. Random traffic then mixes all of these against a bench model.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;

    localparam int          CTX_SLOTS  = 12;
    localparam logic [5:0]  OPC_RTYPE  = 6'b000000;
    localparam logic [5:0]  FN_CTXSAVE = 6'b111100;
    localparam logic [5:0]  FN_CTXLOAD = 6'b111101;

    typedef logic [4:0] regidx_t;

    typedef struct packed {
        logic save;
        logic restore;
    } ctx_op_t;

    // slot 0..7 -> r16..r23, slot 8..11 -> r28..r31
    function automatic regidx_t slot_to_reg(input int s);
        if (s < 8) return regidx_t'(16 + s);
        else       return regidx_t'(20 + s);
    endfunction

    function automatic logic is_ctx_reg(input int r);
        return ((r >= 16) && (r <= 23)) || (r >= 28);
    endfunction

endpackage

// File: rtl/ctxrf_decode.sv
module ctxrf_decode
    import ctxrf_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              instr_vld,
    input  logic [31:0]       instr,
    input  logic              save_stb,
    input  logic              restore_stb,
    input  logic [BANK_W-1:0] stb_bank,
    output ctx_op_t           op,
    output logic [BANK_W-1:0] bank
);

    logic unused_instr_bits;
    assign unused_instr_bits = ^{instr[25:16+BANK_W], instr[15:6]};

    always_comb begin
        op   = '0;
        bank = stb_bank;
        if (save_stb || restore_stb) begin
            op.save    = save_stb;
            op.restore = restore_stb;
        end else if (instr_vld && (instr[31:26] == OPC_RTYPE)) begin
            op.save    = (instr[5:0] == FN_CTXSAVE);
            op.restore = (instr[5:0] == FN_CTXLOAD);
            bank       = instr[16 +: BANK_W];
        end
    end

endmodule

// File: rtl/ctxrf_live.sv
module ctxrf_live
    import ctxrf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [AW-1:0]                       wr_addr,
    input  logic [XLEN-1:0]                     wr_data,
    input  logic                                load_en,
    input  logic [CTX_SLOTS-1:0][XLEN-1:0]      load_vec,
    output logic [NREG-1:0][XLEN-1:0]           regs_o
);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] r;
    } live_t;

    live_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.r[wr_addr] = wr_data;
        end
        if (load_en) begin
            for (int s = 0; s < CTX_SLOTS; s++) begin
                s_d.r[slot_to_reg(s)] = load_vec[s];
            end
        end
        s_d.r[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs_o = s_q.r;

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.r[0] == '0);

    for (genvar g = 1; g < NREG; g++) begin : g_keep
        if (!is_ctx_reg(g)) begin : g_nonctx
            assert_nonctx_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && (wr_addr == AW'(g))) |=> $stable(s_q.r[g]));
        end
    end

    for (genvar s = 0; s < CTX_SLOTS; s++) begin : g_load
        assert_restore_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            load_en |=> s_q.r[slot_to_reg(s)] == $past(load_vec[s]));
    end

endmodule

// File: rtl/ctxrf_banks.sv
module ctxrf_banks
    import ctxrf_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NBANK = 4,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            save_en,
    input  logic [BW-1:0]                   bank,
    input  logic [CTX_SLOTS-1:0][XLEN-1:0]  live_ctx,
    output logic [CTX_SLOTS-1:0][XLEN-1:0]  bank_ctx
);

    typedef struct packed {
        logic [NBANK-1:0][CTX_SLOTS-1:0][XLEN-1:0] b;
    } banks_t;

    banks_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (save_en) begin
            s_d.b[bank] = live_ctx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bank_ctx = s_q.b[bank];

    assert_save_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> s_q.b[$past(bank)] == $past(live_ctx));

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        assert_other_bank_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(save_en && (bank == BW'(k))) |=> $stable(s_q.b[k]));
    end

endmodule

// File: rtl/ctxrf_top.sv
module ctxrf_top
    import ctxrf_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREG  = 32,
    parameter int NBANK = 4,
    localparam int AW   = $clog2(NREG),
    localparam int BW   = $clog2(NBANK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_b,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_stb,
    input  logic            restore_stb,
    input  logic [BW-1:0]   stb_bank,
    input  logic            instr_vld,
    input  logic [31:0]     instr
);

    ctx_op_t                        dec_op;
    logic [BW-1:0]                  dec_bank;
    logic [NREG-1:0][XLEN-1:0]      live_regs;
    logic [CTX_SLOTS-1:0][XLEN-1:0] ctx_live;
    logic [CTX_SLOTS-1:0][XLEN-1:0] ctx_bank;

    ctxrf_decode #(.BANK_W(BW)) u_dec (
        .instr_vld   (instr_vld),
        .instr       (instr),
        .save_stb    (save_stb),
        .restore_stb (restore_stb),
        .stb_bank    (stb_bank),
        .op          (dec_op),
        .bank        (dec_bank)
    );

    for (genvar s = 0; s < CTX_SLOTS; s++) begin : g_gather
        assign ctx_live[s] = live_regs[slot_to_reg(s)];
    end

    ctxrf_live #(.XLEN(XLEN), .NREG(NREG)) u_live (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_en  (dec_op.restore),
        .load_vec (ctx_bank),
        .regs_o   (live_regs)
    );

    ctxrf_banks #(.XLEN(XLEN), .NBANK(NBANK)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (dec_op.save),
        .bank     (dec_bank),
        .live_ctx (ctx_live),
        .bank_ctx (ctx_bank)
    );

    assign rd_data_a = live_regs[rd_addr_a];
    assign rd_data_b = live_regs[rd_addr_b];

    assert_bad_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_stb && !restore_stb && (!instr_vld || instr[31:26] != OPC_RTYPE))
        |-> !dec_op.save && !dec_op.restore);

    assert_strobe_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (save_stb || restore_stb) |-> (dec_bank == stb_bank)
            && (dec_op.save == save_stb) && (dec_op.restore == restore_stb));

    assert_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

endmodule

// File: tb/sim_ctxrf_top.sv
module sim_ctxrf_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data, instr;
    logic        wr_en, save_stb, restore_stb, instr_vld;
    logic [1:0]  stb_bank;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_live [32];
    logic [31:0] m_bank [4][12];

    always #10 clk = ~clk;

    ctxrf_top u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_stb(save_stb), .restore_stb(restore_stb), .stb_bank(stb_bank),
        .instr_vld(instr_vld), .instr(instr)
    );

    function automatic int ctx_reg(input int s);
        return (s < 8) ? 16 + s : 20 + s;
    endfunction

    function automatic logic [31:0] mk_instr(input logic [5:0] opc, input logic [4:0] rt,
                                             input logic [5:0] fn);
        return {opc, 5'd7, rt, 5'd9, 5'd3, fn};
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic cycle(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                         input logic sv, input logic rs, input logic [1:0] sb,
                         input logic iv, input logic [31:0] ins);
        logic        e_sv, e_rs;
        logic [1:0]  e_b;
        logic [31:0] n_live [32];
        wr_en = we; wr_addr = wa; wr_data = wd;
        save_stb = sv; restore_stb = rs; stb_bank = sb;
        instr_vld = iv; instr = ins;
        e_sv = 1'b0; e_rs = 1'b0; e_b = sb;
        if (sv || rs) begin
            e_sv = sv; e_rs = rs;
        end else if (iv && ins[31:26] == 6'b000000) begin
            e_sv = (ins[5:0] == 6'b111100);
            e_rs = (ins[5:0] == 6'b111101);
            e_b  = ins[17:16];
        end
        n_live = m_live;
        if (we && wa != 5'd0) n_live[wa] = wd;
        if (e_rs) for (int s = 0; s < 12; s++) n_live[ctx_reg(s)] = m_bank[e_b][s];
        @(posedge clk);
        #1;
        if (e_sv) for (int s = 0; s < 12; s++) m_bank[e_b][s] = m_live[ctx_reg(s)];
        m_live = n_live;
        wr_en = 1'b0; save_stb = 1'b0; restore_stb = 1'b0; instr_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle();
        cycle(1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cycle(1'b1, 5'(a), d, 1'b0, 1'b0, 2'd0, 1'b0, 32'd0);
    endtask

    task automatic check_reg(input int a, input string tag);
        rd_addr_a = 5'(a);
        rd_addr_b = 5'(31 - a);
        #1;
        n_cmp++;
        if (rd_data_a !== m_live[a]) begin
            n_bad++;
            $display("FAIL %s: port A r%0d actual=%h expected=%h", tag, a, rd_data_a, m_live[a]);
        end
        n_cmp++;
        if (rd_data_b !== m_live[31 - a]) begin
            n_bad++;
            $display("FAIL %s: port B r%0d actual=%h expected=%h", tag, 31 - a, rd_data_b,
                     m_live[31 - a]);
        end
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 32; a++) check_reg(a, tag);
    endtask

    task automatic fill(input logic [31:0] base);
        for (int a = 1; a < 32; a++) wr(a, base ^ (32'h0101_0101 * a));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 32; a++) m_live[a] = '0;
        for (int b = 0; b < 4; b++) for (int s = 0; s < 12; s++) m_bank[b][s] = '0;
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; save_stb = 0; restore_stb = 0;
        stb_bank = 0; instr_vld = 0; instr = 0; rd_addr_a = 0; rd_addr_b = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of live registers and of every bank
        check_all("R1");
        for (int b = 0; b < 4; b++) begin
            fill(32'hA5A5_0000 + b);
            cycle(1'b0, 5'd0, 0, 1'b0, 1'b1, 2'(b), 1'b0, 0);
            check_all("R1");
        end

        // R2: register 0
        wr(0, 32'hDEAD_BEEF);
        check_reg(0, "R2");

        // R3: plain write then read
        wr(5, 32'h1234_5678);
        check_reg(5, "R3");
        wr(31, 32'hCAFE_F00D);
        check_reg(31, "R3");

        // R4 R5 R6: per-bank round trip
        for (int b = 0; b < 4; b++) begin
            fill(32'h1000_0000 * (b + 1));
            cycle(1'b0, 5'd0, 0, 1'b1, 1'b0, 2'(b), 1'b0, 0);
        end
        for (int b = 0; b < 4; b++) begin
            fill(32'hFFFF_0000 - b);
            cycle(1'b0, 5'd0, 0, 1'b0, 1'b1, 2'(b), 1'b0, 0);
            check_all("R4");
            check_all("R5");
            check_reg(10, "R6");
            check_reg(25, "R6");
        end

        // R7: instruction decode with junk in upper rt bits
        fill(32'h7777_0000);
        cycle(0, 0, 0, 0, 0, 0, 1'b1, mk_instr(6'b000000, 5'b10110, 6'b111100));
        fill(32'h0BAD_0000);
        cycle(0, 0, 0, 0, 0, 0, 1'b1, mk_instr(6'b000000, 5'b11110, 6'b111101));
        check_all("R7");

        // R8: non-matching instructions do nothing
        fill(32'h3333_0000);
        cycle(0, 0, 0, 0, 0, 0, 1'b1, mk_instr(6'b000001, 5'd1, 6'b111101));
        check_all("R8");
        cycle(0, 0, 0, 0, 0, 0, 1'b1, mk_instr(6'b000000, 5'd1, 6'b111110));
        check_all("R8");
        cycle(0, 0, 0, 0, 0, 0, 1'b0, mk_instr(6'b000000, 5'd1, 6'b111101));
        check_all("R8");

        // R9: write collides with restore
        cycle(1'b1, 5'd17, 32'h5555_AAAA, 1'b0, 1'b1, 2'd0, 1'b0, 0);
        check_reg(17, "R9");
        cycle(1'b1, 5'd6, 32'h6666_1111, 1'b0, 1'b1, 2'd1, 1'b0, 0);
        check_reg(6, "R9");

        // R10: save takes pre-edge value
        cycle(1'b1, 5'd20, 32'h2020_2020, 1'b1, 1'b0, 2'd2, 1'b0, 0);
        check_reg(20, "R10");
        wr(20, 32'h0);
        cycle(0, 0, 0, 1'b0, 1'b1, 2'd2, 1'b0, 0);
        check_reg(20, "R10");

        // R11: swap
        fill(32'h1111_0000);
        cycle(0, 0, 0, 1'b1, 1'b0, 2'd3, 1'b0, 0);
        fill(32'h2222_0000);
        cycle(0, 0, 0, 1'b1, 1'b1, 2'd3, 1'b0, 0);
        check_all("R11");
        cycle(0, 0, 0, 1'b0, 1'b1, 2'd3, 1'b0, 0);
        check_all("R11");

        // R12: strobe beats instruction
        fill(32'h4444_0000);
        cycle(0, 0, 0, 1'b0, 1'b1, 2'd1, 1'b1, mk_instr(6'b000000, 5'd3, 6'b111100));
        check_all("R12");
        cycle(0, 0, 0, 1'b0, 1'b1, 2'd3, 1'b0, 0);
        check_all("R12");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rnd, ins;
            logic [5:0]  fn, opc;
            rnd = $urandom;
            case (rnd[3:2])
                2'd0:    fn = 6'b111100;
                2'd1:    fn = 6'b111101;
                default: fn = 6'($urandom);
            endcase
            opc = (rnd[6:4] == 3'd0) ? 6'($urandom) : 6'b000000;
            ins = mk_instr(opc, 5'($urandom), fn);
            cycle(rnd[7], 5'($urandom), $urandom,
                  (rnd[11:8] == 4'd0), (rnd[15:12] == 4'd0), rnd[17:16],
                  rnd[18], ins);
            check_reg(int'($urandom_range(0, 31)), "R4");
            if (i % 50 == 49) check_all("R6");
        end

        idle();
        finish_run();
    end

endmodule